// File: doc/BRIEF.md
# Slow-Clock Timer with Snapshot Read

This block keeps a free-running 24-bit tick count that advances on every rising edge of a slow clock of about 32 kHz. All of its logic runs on the fast system clock. The slow clock is sampled through a short synchronizer chain, and each detected rising edge adds one to the count. The count wraps to zero after its all-ones value.

Software reads the count as three bytes through a small read port. A read of byte address 0 returns the low byte of the visible count. The same read copies all 24 bits into a snapshot register. Reads of addresses 1 and 2 return the middle and high bytes of that snapshot, so a low-then-middle-then-high sequence yields one coherent value even when the count moves between the reads. Address 3 returns a status byte that holds the synchronized slow-clock level, which software polls for a rising transition, and a stale flag.

A level input, `resume`, marks the visible count as stale after a stretch of gated system clock. While the count is stale, the visible copy is frozen. It is refreshed by the first slow-clock rising edge that is detected once `resume` has gone low.

Top module: `lft_reader`

## Requirements
- R1: After reset the count, the visible count and the snapshot equal START_VAL (default 0), stale is 0 and rd_data is 0.
- R2: The count rises by exactly one on each detected slow-clock rising edge, stays unchanged otherwise, and wraps from 0xFFFFFF to 0x000000.
- R3: slow_lvl equals slow_clk as sampled two system-clock edges earlier (a two-flop synchronizer). A rising edge counts as detected when the synchronized level is 1 and was 0 on the edge before.
- R4: stale reads 1 on the edge after any cycle with resume high. It returns to 0 on the first edge where resume is low and a rising edge is detected.
- R5: While stale is 0 the visible count equals the count. While stale is 1 the visible count holds its value.
- R6: A read (rd_en high) of address 0 puts bits [7:0] of the visible count on rd_data on the next edge. The same read copies the full visible count into the snapshot.
- R7: Reads of address 1 and address 2 return snapshot bits [15:8] and [23:16], taken at the last address-0 read, and never the live count.
- R8: A read of address 3 returns the status byte: bit 1 is stale, bit 0 is slow_lvl, and bits 7:2 are 0.
- R9: rd_data holds its last value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | Slow clock, asynchronous to clk |
| resume | input | 1 | Level input; while high, marks the visible count stale |
| rd_en | input | 1 | Read strobe, one per cycle |
| rd_addr | input | 2 | Byte address: 0 low, 1 middle, 2 high, 3 status |
| rd_data | output | 8 | Registered read data |
| slow_lvl | output | 1 | Synchronized slow-clock level |
| stale | output | 1 | Visible count is stale |

## Verification
The hardest case to reach from the ports is the counter wrap, because it needs about sixteen million slow edges from a zero start. The bench therefore builds the block with a start value just below the all-ones count, so the wrap occurs within a few hundred slow periods. A second hard case is a snapshot that disagrees with the live count. To produce it, the bench reads the low byte and lets many slow edges pass before reading the upper bytes. It also holds resume high across several edges so the frozen visible count can be told apart from the running one.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int STAT_LVL_BIT   = 0;
  localparam int STAT_STALE_BIT = 1;

  // Add one within a width of w bits (wraps to zero)
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

  // Pick byte idx (of width bw) out of v
  function automatic logic [7:0] byte_of(input logic [31:0] v, input int unsigned idx,
                                         input int unsigned bw);
    logic [31:0] s;
    s = v >> (idx * bw);
    return s[7:0];
  endfunction
endpackage

// File: rtl/lft_sync.sv
module lft_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], async_in};
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/lft_counter.sv
module lft_counter #(
  parameter int               W         = 24,
  parameter logic [W-1:0]     START_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         resume,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] vis_o,
  output logic         stale_o
);
  import lft_pkg::*;

  logic [W-1:0] cnt_q, vis_q, cnt_n, inc_v;
  logic         stale_q, stale_n;
  logic [31:0]  inc_w;

  always_comb begin
    inc_w   = wrap_inc(32'(cnt_q), W);
    inc_v   = inc_w[W-1:0];
    cnt_n   = rise ? inc_v : cnt_q;
    if (resume)    stale_n = 1'b1;
    else if (rise) stale_n = 1'b0;
    else           stale_n = stale_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= START_VAL;
      vis_q   <= START_VAL;
      stale_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      stale_q <= stale_n;
      if (!stale_n) vis_q <= cnt_n;
    end
  end

  assign cnt_o   = cnt_q;
  assign vis_o   = vis_q;
  assign stale_o = stale_q;
endmodule

// File: rtl/lft_regs.sv
module lft_regs #(
  parameter int W      = 24,
  parameter int BW     = 8,
  parameter int ADDR_W = 2,
  parameter logic [W-1:0] START_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      vis,
  input  logic              stale,
  input  logic              lvl,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BW-1:0]     rd_data,
  output logic [W-1:0]      snap_o
);
  import lft_pkg::*;

  localparam int NB = W / BW;

  logic [W-1:0]  snap_q;
  logic [BW-1:0] snap_byte [NB];
  logic [BW-1:0] status_b;
  logic [BW-1:0] rd_mux;

  for (genvar b = 0; b < NB; b++) begin : g_bytes
    assign snap_byte[b] = snap_q[b*BW +: BW];
  end

  always_comb begin
    status_b                 = '0;
    status_b[STAT_LVL_BIT]   = lvl;
    status_b[STAT_STALE_BIT] = stale;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == '0) begin
      rd_mux = vis[BW-1:0];
    end else if (32'(rd_addr) == NB) begin
      rd_mux = status_b;
    end else begin
      for (int b = 1; b < NB; b++)
        if (32'(rd_addr) == b) rd_mux = snap_byte[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= START_VAL;
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
      if (rd_addr == '0) snap_q <= vis;
    end
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/lft_reader.sv
module lft_reader #(
  parameter int           CNT_W       = 24,
  parameter int           BYTE_W      = 8,
  parameter int           SYNC_STAGES = 2,
  parameter int           ADDR_W      = $clog2(CNT_W / BYTE_W + 1),
  parameter logic [CNT_W-1:0] START_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              resume,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              slow_lvl,
  output logic              stale
);
  logic             rise_evt;
  logic [CNT_W-1:0] cnt_q, vis_q, snap_q;

  lft_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_clk),
    .level_o(slow_lvl), .rise_o(rise_evt)
  );

  lft_counter #(.W(CNT_W), .START_VAL(START_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .resume(resume),
    .cnt_o(cnt_q), .vis_o(vis_q), .stale_o(stale)
  );

  lft_regs #(.W(CNT_W), .BW(BYTE_W), .ADDR_W(ADDR_W), .START_VAL(START_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .vis(vis_q), .stale(stale), .lvl(slow_lvl),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .snap_o(snap_q)
  );
endmodule

// File: rtl/lft_reader_chk.sv
module lft_reader_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              resume,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rise_evt,
  input logic              stale,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  vis_q,
  input logic [CNT_W-1:0]  snap_q
);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(cnt_q));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R4
  stale_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> stale);

  // R5
  vis_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stale |-> vis_q == cnt_q);

  // R5
  vis_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && (resume || !rise_evt)) |=> $stable(vis_q));

  // R6
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == '0) |=> snap_q == $past(vis_q));

  // R7
  snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == '0) |=> $stable(snap_q));
endmodule

bind lft_reader lft_reader_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .resume(resume), .rd_en(rd_en), .rd_addr(rd_addr),
  .rise_evt(rise_evt), .stale(stale), .cnt_q(cnt_q), .vis_q(vis_q), .snap_q(snap_q)
);

// File: tb/lft_reader_test.sv
module lft_reader_test;
  localparam logic [23:0] START = 24'hFFFFC0;
  localparam int MASK = 24'hFFFFFF;

  logic clk = 0, rst_n = 0, slow_clk = 0, resume = 0, rd_en = 0;
  logic [1:0] rd_addr = 0;
  logic slow_run = 0;
  wire [7:0] rd_data;
  wire slow_lvl, stale;

  always #10 clk = ~clk;

  lft_reader #(.START_VAL(START)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .resume(resume),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .slow_lvl(slow_lvl), .stale(stale)
  );

  int vectors = 0, errors = 0;
  string tag = "R1";
  bit started = 0, done = 0;

  // reference model
  bit q[$] = '{0, 0, 0};
  int m_cnt, m_vis, m_snap, m_rd, m_stale, m_lvl, wraps = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = '{0, 0, 0};
      m_cnt = START; m_vis = START; m_snap = START; m_rd = 0; m_stale = 0; m_lvl = 0;
    end else begin
      bit rise;
      int old_vis, old_stale, old_lvl;
      rise = q[1] && !q[2];
      old_vis = m_vis; old_stale = m_stale; old_lvl = q[1];
      if (rd_en) begin
        case (rd_addr)
          2'd0: begin m_rd = old_vis & 255; m_snap = old_vis; end
          2'd1: m_rd = (m_snap >> 8) & 255;
          2'd2: m_rd = (m_snap >> 16) & 255;
          default: m_rd = old_stale * 2 + old_lvl;
        endcase
      end
      q.push_front(slow_clk);
      void'(q.pop_back());
      m_lvl = q[1];
      if (rise) begin
        m_cnt = (m_cnt + 1) & MASK;
        if (m_cnt == 0) wraps++;
      end
      if (resume) m_stale = 1;
      else if (rise) m_stale = 0;
      if (m_stale == 0) m_vis = m_cnt;
    end
    started = 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (started && !done) begin
      check({tag, " R6 R7 R8 R9"}, "rd_data", int'(rd_data), m_rd);
      check("R3", "slow_lvl", int'(slow_lvl), m_lvl);
      check("R4", "stale", int'(stale), m_stale);
    end
  end

  // slow clock source with varying half periods
  int k = 0;
  always begin
    @(negedge clk);
    if (slow_run) begin
      repeat (2 + (k % 5)) @(negedge clk);
      slow_clk = ~slow_clk;
      k++;
    end
  end

  task automatic rd(input logic [1:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hold, snapv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "rd_data reset", int'(rd_data), 0);
    check("R1", "stale reset", int'(stale), 0);
    rd(2'd0);
    check("R1", "low byte after reset", int'(rd_data), int'(START[7:0]));
    rd(2'd2);
    check("R1", "high byte of start", int'(rd_data), int'(START[23:16]));

    // R2 R3 counting
    tag = "R2";
    slow_run = 1;
    repeat (60) @(negedge clk);
    rd(2'd0);
    check("R2", "low byte moving", int'(rd_data), m_vis & 255);
    rd(2'd3);
    check("R8", "status byte", int'(rd_data), m_rd);

    // R7 snapshot is not live
    tag = "R7";
    rd(2'd0);
    snapv = m_snap;
    repeat (80) @(negedge clk);
    rd(2'd1);
    check("R7", "mid from snapshot", int'(rd_data), (snapv >> 8) & 255);
    rd(2'd2);
    check("R7", "high from snapshot", int'(rd_data), (snapv >> 16) & 255);

    // R9 hold without read
    tag = "R9";
    hold = int'(rd_data);
    repeat (30) @(negedge clk);
    check("R9", "rd_data held", int'(rd_data), hold);

    // R2 wrap
    tag = "R2";
    while (wraps == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    rd(2'd0); rd(2'd1); rd(2'd2);
    check("R2", "high byte after wrap", int'(rd_data), 0);

    // R4 R5 stale freeze
    tag = "R5";
    @(negedge clk); resume = 1;
    @(negedge clk);
    hold = m_vis;
    check("R4", "stale set", int'(stale), 1);
    repeat (50) @(negedge clk);
    rd(2'd0);
    check("R5", "frozen low byte", int'(rd_data), hold & 255);
    rd(2'd3);
    check("R8", "status stale bit", (int'(rd_data) >> 1) & 1, 1);
    resume = 0;
    while (m_stale == 1) @(negedge clk);
    @(negedge clk);
    check("R4", "stale cleared", int'(stale), 0);
    rd(2'd0);
    check("R5", "refreshed low byte", int'(rd_data), m_vis & 255);
    check("R5", "refreshed differs", int'(m_vis != hold), 1);

    // mixed traffic
    tag = "R6";
    for (int i = 0; i < 40; i++) begin
      rd(2'(i % 4));
      repeat (i % 7) @(negedge clk);
      if (i == 20) resume = 1;
      if (i == 24) resume = 0;
    end
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule